// File: doc/BRIEF.md
# Translation Cache Maintenance Sequencer

This block carries out maintenance on a group of translation caches on behalf of software. The group is a set of per-master micro TLBs, one shared macro TLB and one page-table-walk cache. Software writes command bits through a small word-addressed register port. A command is either a full flush of chosen caches, or an invalidation of one address under a mask. The block raises a request line to each cache involved and holds it until that cache acknowledges. Software polls the command bits: each one reads as set while its work is pending or in flight, and reads zero once it is done.

Only one operation runs at a time. A command written while another is in flight is held and starts later; it is not lost. When an address invalidation starts, the address and mask are captured. Software may then reprogram the address registers at once. Each cache compares its own entries against the presented tag and mask: an entry matches when its address ANDed with the mask equals the tag. A cache that never acknowledges leaves its request and its command bit set, so software can give up after its own timeout.

Top module: `tlb_maint_ctrl`

## Requirements
- R1: After reset every register reads zero and no target request is raised.
- R2: Register 0 is the flush register. Writing it raises one request for each selected target, in the second cycle after the write. Bits 0 to NUM_MICRO-1 select micro TLBs 0 to NUM_MICRO-1, which are targets 0 to NUM_MICRO-1. Bit 16 selects the macro TLB, which is target NUM_MICRO. Bit 17 selects the walk cache, which is target NUM_MICRO+1. During a flush `tgtInv` is 0. The selected bits read back as 1.
- R3: A request and its flush bit stay set until that target acknowledges. They both clear at the clock edge that samples the acknowledge. The other targets are not affected.
- R4: An acknowledge from a target that is not being requested has no effect.
- R5: Writing 1 to bit 0 of register 3 starts a TLB invalidation. It requests targets 0 to NUM_MICRO with `tgtInv`=1. It presents `tgtTag` = (register 1 AND register 2) and `tgtMask` = register 2. Register 3 bit 0 reads 1 until every one of those targets has acknowledged.
- R6: Writing 1 to bit 0 of register 5 starts a walk-cache invalidation. It requests only target NUM_MICRO+1, with `tgtInv`=1. It presents `tgtMask` = WALK_MASK (default 0xFFF00000) and `tgtTag` = (register 4 AND WALK_MASK). Register 5 bit 0 reads 1 until that target acknowledges.
- R7: Only one operation runs at a time. A command written while another is busy stays set and starts after the current one ends. Rewriting the command that is now running makes it run once more.
- R8: When several commands are pending, the order is fixed: flush first, then TLB invalidation, then walk-cache invalidation.
- R9: Writing the address or mask registers while an operation is in flight leaves the presented tag and mask unchanged.
- R10: A target that never acknowledges keeps its request raised and its command bit set for as long as it stays silent.
- R11: Zero bits in a command write have no effect. Flush-register bits other than the defined ones are ignored and read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word index |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for `regAddr` (combinational) |
| tgtReq | output | NUM_MICRO+2 | Per-target maintenance request, held until acknowledged |
| tgtInv | output | 1 | 1: address invalidation, 0: full flush |
| tgtTag | output | 32 | Masked address to match against |
| tgtMask | output | 32 | Address mask for matching |
| tgtAck | input | NUM_MICRO+2 | Per-target completion pulse |

## Verification
The bench keeps the default build: six micro TLBs and a 1 MiB walk-cache mask. This gives eight targets, so every flush-register bit and every target line is driven. The acknowledges are driven by hand, which makes it possible to create partial completion, acknowledges from targets that were never asked, and a target that stays silent for many cycles. Commands are piled up while one target is held busy. This shows the queue order, a rerun of the running command, and that the captured tag does not change while the address registers are rewritten.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;
  localparam int REG_W = 32;

  localparam logic [2:0] REG_FLUSH    = 3'd0;
  localparam logic [2:0] REG_INV_ADDR = 3'd1;
  localparam logic [2:0] REG_INV_MASK = 3'd2;
  localparam logic [2:0] REG_INV_GO   = 3'd3;
  localparam logic [2:0] REG_WLK_ADDR = 3'd4;
  localparam logic [2:0] REG_WLK_GO   = 3'd5;

  localparam int FLUSH_MACRO_BIT = 16;
  localparam int FLUSH_WALK_BIT  = 17;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_FLUSH   = 2'd1,
    ST_TLBINV  = 2'd2,
    ST_WALKINV = 2'd3
  } opState_e;

  typedef struct packed {
    logic snapTlb;
    logic snapWalk;
  } dpStrobe_t;
endpackage

// File: rtl/tlbm_datapath.sv
module tlbm_datapath
  import tlbm_pkg::*;
#(
  parameter int               NUM_MICRO = 6,
  parameter logic [REG_W-1:0] WALK_MASK = 32'hFFF0_0000,
  localparam int NT = NUM_MICRO + 2,
  localparam int NC = NT + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [2:0]       regAddr,
  input  logic [REG_W-1:0] regWdata,
  input  dpStrobe_t        strb,
  input  logic [NC-1:0]    cmdFlag,
  output logic [NC-1:0]    cmdWr,
  output logic [REG_W-1:0] regRdata,
  output logic [REG_W-1:0] tgtTag,
  output logic [REG_W-1:0] tgtMask
);
  localparam int MAC = NUM_MICRO;
  localparam int WLK = NUM_MICRO + 1;
  localparam int TGO = NT;
  localparam int WGO = NT + 1;

  logic [REG_W-1:0] invAddr, invMask, walkAddr;
  logic [REG_W-1:0] tagQ, maskQ;

  // command bit decode
  always_comb begin
    cmdWr = '0;
    if (regWe) begin
      case (regAddr)
        REG_FLUSH: begin
          for (int i = 0; i < NUM_MICRO; i++) cmdWr[i] = regWdata[i];
          cmdWr[MAC] = regWdata[FLUSH_MACRO_BIT];
          cmdWr[WLK] = regWdata[FLUSH_WALK_BIT];
        end
        REG_INV_GO: cmdWr[TGO] = regWdata[0];
        REG_WLK_GO: cmdWr[WGO] = regWdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      invAddr  <= '0;
      invMask  <= '0;
      walkAddr <= '0;
    end else if (regWe) begin
      if (regAddr == REG_INV_ADDR) invAddr  <= regWdata;
      if (regAddr == REG_INV_MASK) invMask  <= regWdata;
      if (regAddr == REG_WLK_ADDR) walkAddr <= regWdata;
    end
  end

  // captured match operands, frozen for the whole operation
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tagQ  <= '0;
      maskQ <= '0;
    end else if (strb.snapTlb) begin
      tagQ  <= invAddr & invMask;
      maskQ <= invMask;
    end else if (strb.snapWalk) begin
      tagQ  <= walkAddr & WALK_MASK;
      maskQ <= WALK_MASK;
    end
  end

  assign tgtTag  = tagQ;
  assign tgtMask = maskQ;

  always_comb begin
    regRdata = '0;
    case (regAddr)
      REG_FLUSH: begin
        for (int i = 0; i < NUM_MICRO; i++) regRdata[i] = cmdFlag[i];
        regRdata[FLUSH_MACRO_BIT] = cmdFlag[MAC];
        regRdata[FLUSH_WALK_BIT]  = cmdFlag[WLK];
      end
      REG_INV_ADDR: regRdata = invAddr;
      REG_INV_MASK: regRdata = invMask;
      REG_INV_GO:   regRdata[0] = cmdFlag[TGO];
      REG_WLK_ADDR: regRdata = walkAddr;
      REG_WLK_GO:   regRdata[0] = cmdFlag[WGO];
      default: ;
    endcase
  end
endmodule

// File: rtl/tlbm_ctrl.sv
module tlbm_ctrl
  import tlbm_pkg::*;
#(
  parameter int NUM_MICRO = 6,
  localparam int NT = NUM_MICRO + 2,
  localparam int NC = NT + 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [NC-1:0] cmdWr,
  input  logic [NT-1:0] tgtAck,
  output logic [NC-1:0] cmdFlag,
  output dpStrobe_t     strb,
  output logic [NT-1:0] tgtReq,
  output logic          tgtInv
);
  localparam int TGO = NT;
  localparam int WGO = NT + 1;
  localparam logic [NT-1:0] TLB_SET  = {1'b0, {(NUM_MICRO + 1){1'b1}}};
  localparam logic [NT-1:0] WALK_SET = {1'b1, {(NT - 1){1'b0}}};

  opState_e      state;
  logic [NT-1:0] act;
  logic          invQ;
  logic [NT-1:0] actNext;
  logic          opDone;
  logic [NC-1:0] cmdActive, cmdDone, again;

  assign actNext = act & ~tgtAck;
  assign opDone  = (state != ST_IDLE) && (actNext == '0);

  always_comb begin
    for (int i = 0; i < NT; i++) begin
      cmdActive[i] = (state == ST_FLUSH) && act[i];
      cmdDone[i]   = (state == ST_FLUSH) && act[i] && tgtAck[i];
    end
    cmdActive[TGO] = (state == ST_TLBINV);
    cmdDone[TGO]   = (state == ST_TLBINV) && opDone;
    cmdActive[WGO] = (state == ST_WALKINV);
    cmdDone[WGO]   = (state == ST_WALKINV) && opDone;
  end

  // per command bit: pending flag plus one queued rerun
  for (genvar g = 0; g < NC; g++) begin : g_cmd
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cmdFlag[g] <= 1'b0;
        again[g]   <= 1'b0;
      end else if (cmdDone[g]) begin
        cmdFlag[g] <= again[g] | cmdWr[g];
        again[g]   <= 1'b0;
      end else begin
        cmdFlag[g] <= cmdFlag[g] | (cmdWr[g] & ~cmdActive[g]);
        again[g]   <= again[g] | (cmdWr[g] & cmdActive[g]);
      end
    end
  end

  always_comb begin
    strb = '0;
    if (state == ST_IDLE && cmdFlag[NT-1:0] == '0) begin
      strb.snapTlb  = cmdFlag[TGO];
      strb.snapWalk = ~cmdFlag[TGO] & cmdFlag[WGO];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      act   <= '0;
      invQ  <= 1'b0;
    end else if (state == ST_IDLE) begin
      if (cmdFlag[NT-1:0] != '0) begin
        state <= ST_FLUSH;
        act   <= cmdFlag[NT-1:0];
        invQ  <= 1'b0;
      end else if (cmdFlag[TGO]) begin
        state <= ST_TLBINV;
        act   <= TLB_SET;
        invQ  <= 1'b1;
      end else if (cmdFlag[WGO]) begin
        state <= ST_WALKINV;
        act   <= WALK_SET;
        invQ  <= 1'b1;
      end
    end else begin
      act <= actNext;
      if (opDone) begin
        state <= ST_IDLE;
        invQ  <= 1'b0;
      end
    end
  end

  assign tgtReq = act;
  assign tgtInv = invQ;
endmodule

// File: rtl/tlb_maint_ctrl.sv
module tlb_maint_ctrl
  import tlbm_pkg::*;
#(
  parameter int               NUM_MICRO = 6,
  parameter logic [REG_W-1:0] WALK_MASK = 32'hFFF0_0000,
  localparam int NT = NUM_MICRO + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [2:0]       regAddr,
  input  logic [REG_W-1:0] regWdata,
  output logic [REG_W-1:0] regRdata,
  output logic [NT-1:0]    tgtReq,
  output logic             tgtInv,
  output logic [REG_W-1:0] tgtTag,
  output logic [REG_W-1:0] tgtMask,
  input  logic [NT-1:0]    tgtAck
);
  localparam int NC = NT + 2;

  dpStrobe_t     strb;
  logic [NC-1:0] cmdFlag, cmdWr;

  tlbm_ctrl #(.NUM_MICRO(NUM_MICRO)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .tgtAck(tgtAck),
    .cmdFlag(cmdFlag), .strb(strb), .tgtReq(tgtReq), .tgtInv(tgtInv)
  );

  tlbm_datapath #(.NUM_MICRO(NUM_MICRO), .WALK_MASK(WALK_MASK)) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .strb(strb), .cmdFlag(cmdFlag), .cmdWr(cmdWr),
    .regRdata(regRdata), .tgtTag(tgtTag), .tgtMask(tgtMask)
  );
endmodule

// File: rtl/tlb_maint_ctrl_chk.sv
module tlb_maint_ctrl_chk #(
  parameter int NT = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic [NT-1:0] tgtReq,
  input logic [NT-1:0] tgtAck,
  input logic          tgtInv,
  input logic [31:0]   tgtTag,
  input logic [31:0]   tgtMask
);
  // an unacknowledged request is still there next cycle
  p_hold_until_ack_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((tgtReq & ~tgtAck) != '0) |=>
      ((tgtReq & $past(tgtReq & ~tgtAck)) == $past(tgtReq & ~tgtAck)));

  // requests only appear while nothing is in flight
  p_one_op_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((tgtReq & ~$past(tgtReq)) != '0) |-> ($past(tgtReq) == '0));

  // walk invalidation addresses the walk cache alone
  p_walk_inv_alone_r6: assert property (@(posedge clk) disable iff (!rstN)
    (tgtInv && tgtReq[NT-1]) |-> (tgtReq[NT-2:0] == '0));

  // operands frozen while one operation continues
  p_snapshot_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((tgtReq != '0) && ($past(tgtReq) != '0)) |->
      ($stable(tgtTag) && $stable(tgtMask) && $stable(tgtInv)));
endmodule

bind tlb_maint_ctrl tlb_maint_ctrl_chk #(.NT(NT)) u_chk (
  .clk(clk), .rstN(rstN), .tgtReq(tgtReq), .tgtAck(tgtAck),
  .tgtInv(tgtInv), .tgtTag(tgtTag), .tgtMask(tgtMask)
);

// File: tb/tlb_maint_ctrl_tb.sv
module tlb_maint_ctrl_tb;
  localparam int NT = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [NT-1:0] tgtReq;
  logic        tgtInv;
  logic [31:0] tgtTag, tgtMask;
  logic [NT-1:0] tgtAck = '0;

  int nRun = 0;
  int nFail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  tlb_maint_ctrl u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .tgtReq(tgtReq),
    .tgtInv(tgtInv), .tgtTag(tgtTag), .tgtMask(tgtMask), .tgtAck(tgtAck)
  );

  typedef struct packed {
    logic [2:0]  addr;
    logic [31:0] data;
    logic [7:0]  req;
    logic        inv;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{3'd0, 32'h0003_003F, 8'hFF, 1'b0},   // R2 all targets
    '{3'd0, 32'h0000_0004, 8'h04, 1'b0},   // R2 one micro
    '{3'd0, 32'h0001_0000, 8'h40, 1'b0},   // R2 macro
    '{3'd0, 32'h0002_0000, 8'h80, 1'b0},   // R2 walk cache
    '{3'd0, 32'hFFFC_FFC0, 8'h00, 1'b0},   // R11 undefined bits
    '{3'd3, 32'h0000_0000, 8'h00, 1'b0},   // R11 zero go
    '{3'd3, 32'h0000_0001, 8'h7F, 1'b1},   // R5 TLB invalidate
    '{3'd5, 32'h0000_0001, 8'h80, 1'b1}    // R6 walk invalidate
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic ack(logic [NT-1:0] m);
    tgtAck = m;
    @(negedge clk);
    tgtAck = '0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] v);
    regAddr = a;
    #1 v = regRdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 req", 32'(tgtReq), 0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check("R1 reg", v, 0);
    end
    rstN = 1'b1;
    @(negedge clk);

    // walk cache address for R6 vector
    wr(3'd4, 32'h1234_5678);

    for (int i = 0; i < 8; i++) begin
      wr(VEC[i].addr, VEC[i].data);
      @(negedge clk);
      check("R2/R5/R6/R11 req", 32'(tgtReq), 32'(VEC[i].req));
      if (VEC[i].req != 0) check("R2/R5/R6 inv", 32'(tgtInv), 32'(VEC[i].inv));
      if (VEC[i].addr == 3'd5) begin
        check("R6 tag", tgtTag, 32'h1230_0000);
        check("R6 mask", tgtMask, 32'hFFF0_0000);
      end
      rd(VEC[i].addr, v);
      check("R2 readback busy", v, VEC[i].req != 0 ? VEC[i].data & 32'h0003_003F : 0);
      ack(VEC[i].req);
      check("R3 req cleared", 32'(tgtReq), 0);
      rd(VEC[i].addr, v);
      check("R3 readback done", v, 0);
    end

    // R3 partial completion, R4 stray ack
    wr(3'd0, 32'h3);
    @(negedge clk);
    ack(8'h01);
    check("R3 partial req", 32'(tgtReq), 32'h2);
    rd(3'd0, v);
    check("R3 partial reg", v, 32'h2);
    ack(8'h20);
    check("R4 stray ack req", 32'(tgtReq), 32'h2);
    rd(3'd0, v);
    check("R4 stray ack reg", v, 32'h2);
    ack(8'h02);
    check("R3 all done", 32'(tgtReq), 0);

    // R5 tag, R9 snapshot, R7 queue and rerun
    wr(3'd1, 32'h1234_5678);
    wr(3'd2, 32'hFFFF_F000);
    wr(3'd3, 32'h1);
    @(negedge clk);
    check("R5 req", 32'(tgtReq), 32'h7F);
    check("R5 tag", tgtTag, 32'h1234_5000);
    check("R5 mask", tgtMask, 32'hFFFF_F000);
    wr(3'd1, 32'hABCD_E123);
    check("R9 tag frozen", tgtTag, 32'h1234_5000);
    wr(3'd0, 32'h1);
    wr(3'd3, 32'h1);
    check("R7 still tlb", 32'(tgtReq), 32'h7F);
    rd(3'd0, v);
    check("R7 flush queued", v, 32'h1);
    ack(8'h7F);
    check("R7 gap", 32'(tgtReq), 0);
    rd(3'd3, v);
    check("R7 rerun pending", v, 32'h1);
    @(negedge clk);
    check("R7/R8 flush next", 32'(tgtReq), 32'h01);
    ack(8'h01);
    @(negedge clk);
    check("R7 rerun req", 32'(tgtReq), 32'h7F);
    check("R7 rerun tag", tgtTag, 32'hABCD_E000);
    ack(8'h7F);
    rd(3'd3, v);
    check("R7 go clear", v, 0);

    // R8 ordering
    wr(3'd0, 32'h1);
    @(negedge clk);
    wr(3'd5, 32'h1);
    wr(3'd3, 32'h1);
    wr(3'd0, 32'h8);
    ack(8'h01);
    @(negedge clk);
    check("R8 flush first", 32'(tgtReq), 32'h08);
    ack(8'h08);
    @(negedge clk);
    check("R8 tlb second", 32'(tgtReq), 32'h7F);
    ack(8'h7F);
    @(negedge clk);
    check("R8 walk third", 32'(tgtReq), 32'h80);
    check("R8 walk inv", 32'(tgtInv), 1);
    ack(8'h80);
    rd(3'd5, v);
    check("R8 walk go clear", v, 0);

    // R10 stuck target
    wr(3'd0, 32'h0001_0000);
    repeat (40) @(negedge clk);
    check("R10 req held", 32'(tgtReq), 32'h40);
    rd(3'd0, v);
    check("R10 bit held", v, 32'h0001_0000);
    ack(8'h40);
    check("R10 released", 32'(tgtReq), 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule